// File: doc/BRIEF.md
# Oversampled PICC Command Receiver

This block sits on the card side of a contactless link. It takes demodulated reader-to-card data one sample per clock. Each data bit arrives as four samples. Thirty-two samples make one word. In short-frame and standard modes the block ignores the line until it sees a four-sample start pattern. In continuous and one-shot modes it packs from the first sample after the mode is entered. Finished words go into one of two buffer slots that are used in turn. A consumer hands each slot back when it has drained it.

In short-frame mode the first word of each capture is compared with the two oversampled wake-up command patterns. The block then updates a frame-delay count for the response timer. In continuous mode a word with all bits set shows that the line carried no modulation, and the block marks it as empty.

Top module: `picc_cmd_rx`

## Requirements
- R1: After reset, the outputs are as follows:
  - `word_valid_o`, `buf_full_o`, `overrun_o`, `unknown_o` and `empty_o` are 0.
  - `fdt_o` is 1172.
  - Both slots are free and the primary slot is slot 0.
- R2: Thirty-two consecutive samples form one word. The first sample lands in bit 31. `word_valid_o` pulses for one cycle, in the cycle after the clock edge that captured the 32nd sample.
- R3: In short-frame mode (`mode_i`=1) and standard mode (`mode_i`=2), packing starts with the sample that follows a window of three 0 samples and then a 1. No sample before that point is packed.
- R4: In modes 1 and 2, a capture is SHORT_WORDS words (16 by default). After a capture the block hunts for a new start pattern.
- R5: In mode 1, the first word of a capture sets `fdt_o` in the same cycle that the word is presented:
  - 0x10410441 (REQA) sets `fdt_o` to 1172.
  - 0x04041041 (WUPA) sets `fdt_o` to 1236.
- R6: In mode 1, any other first word pulses `unknown_o` and leaves `fdt_o` unchanged.
- R7: In continuous mode (`mode_i`=3), packing starts at the first sample after the mode change. No start pattern is needed. Captures of CONT_WORDS words follow one another without a break.
- R8: In one-shot mode (`mode_i`=4), after one capture of SHORT_WORDS words the block produces no further words until `mode_i` changes.
- R9: Ping-pong slot handling works as follows:
  - Each stored word reports its slot on `slot_o`.
  - The last word of a capture pulses `buf_full_o`. The other slot then becomes primary.
  - A `release_i` pulse frees the oldest full slot.
- R10: A word completed while no slot is free is dropped, so `word_valid_o` stays 0. It also sets `overrun_o`, which holds until reset.
- R11: In mode 3, a word of 0xFFFFFFFF pulses `empty_o` together with `word_valid_o`.
- R12: A change of `mode_i` restarts reception and discards a partly packed word. Mode 0 produces no words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | 0 none, 1 short frame, 2 standard, 3 continuous, 4 one-shot |
| sample_i | input | 1 | Demodulated data sample |
| release_i | input | 1 | Pulse: consumer frees the oldest full slot |
| word_o | output | 32 | Packed word |
| word_valid_o | output | 1 | Word stored this cycle |
| slot_o | output | 1 | Slot holding `word_o` |
| buf_full_o | output | 1 | Last word of a capture; slot handed over |
| overrun_o | output | 1 | Sticky: a word was dropped |
| fdt_o | output | FDT_W | Frame-delay count in carrier cycles |
| unknown_o | output | 1 | Unmatched short-frame first word |
| empty_o | output | 1 | No-modulation word in continuous mode |

## Verification
The bench builds the block with SHORT_WORDS at its default of 16 and with CONT_WORDS lowered to 6. This keeps the 16-word short and one-shot captures true to size, and lets the continuous capture wrap within a few hundred cycles.

Four back-to-back short frames do the following:
- They fill both slots.
- They force a dropped capture.
- After one release they store into the freed slot.

Switching modes in the middle of a word shows that the bit count restarts.

// File: rtl/picc_rx_pkg.sv
package picc_rx_pkg;

  localparam int WORD_W = 32;
  localparam int SOF_LEN = 4;
  localparam logic [SOF_LEN-1:0] SOF_PAT = 4'b0001;

  localparam logic [WORD_W-1:0] REQA_WORD = 32'h1041_0441;
  localparam logic [WORD_W-1:0] WUPA_WORD = 32'h0404_1041;
  localparam int REQA_FDT = 1172;
  localparam int WUPA_FDT = 1236;

  typedef enum logic [2:0] {
    MODE_NONE    = 3'd0,
    MODE_SHORT   = 3'd1,
    MODE_STD     = 3'd2,
    MODE_CONT    = 3'd3,
    MODE_ONESHOT = 3'd4
  } rx_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HUNT,
    ST_RECV,
    ST_DONE
  } rx_state_e;

endpackage

// File: rtl/picc_sof_sync.sv
module picc_sof_sync
  import picc_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic hunt_i,
  input  logic sample_i,
  output logic hit_o
);

  logic [SOF_LEN-1:0] win_q;
  logic [SOF_LEN-1:0] win_n;

  assign win_n = {win_q[SOF_LEN-2:0], sample_i};
  assign hit_o = hunt_i && (win_n == SOF_PAT);

  // preset to all ones so a full pattern must be seen after every clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      win_q <= '1;
    else if (clear_i) win_q <= '1;
    else if (hunt_i)  win_q <= win_n;
  end

endmodule

// File: rtl/picc_word_pack.sv
module picc_word_pack #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         en_i,
  input  logic         sample_i,
  output logic         done_o,
  output logic [W-1:0] word_o
);

  localparam int CNT_W = $clog2(W);

  logic [W-2:0]     sh_q;
  logic [CNT_W-1:0] cnt_q;

  assign done_o = en_i && (cnt_q == CNT_W'(W - 1));
  assign word_o = {sh_q, sample_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (en_i) begin
      sh_q  <= {sh_q[W-3:0], sample_i};
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/picc_pingpong.sv
module picc_pingpong (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic last_i,
  input  logic release_i,
  output logic store_o,
  output logic slot_o,
  output logic overrun_o
);

  logic [1:0] full_q, full_n;
  logic       prim_q;
  logic       oldest;
  logic       ovr_q;

  assign store_o   = wr_i && !full_q[prim_q];
  assign slot_o    = prim_q;
  assign overrun_o = ovr_q;

  // with in-order release, the primary slot is full only when both are
  assign oldest = full_q[prim_q] ? prim_q : ~prim_q;

  always_comb begin
    full_n = full_q;
    if (release_i) full_n[oldest] = 1'b0;
    if (store_o && last_i) full_n[prim_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= '0;
      prim_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      full_q <= full_n;
      if (store_o && last_i) prim_q <= ~prim_q;
      if (wr_i && !store_o)  ovr_q  <= 1'b1;
    end
  end

  a_r10_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |=> ovr_q);

  a_r10_no_store_both_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_q == 2'b11) |-> !store_o);

endmodule

// File: rtl/picc_frame_match.sv
module picc_frame_match
  import picc_rx_pkg::*;
#(
  parameter int FDT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              check_fdt_i,
  input  logic              check_empty_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [FDT_W-1:0]  fdt_o,
  output logic              unknown_o,
  output logic              empty_o
);

  logic [FDT_W-1:0] fdt_q;
  logic             unk_q, emp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fdt_q <= FDT_W'(REQA_FDT);
      unk_q <= 1'b0;
      emp_q <= 1'b0;
    end else begin
      unk_q <= 1'b0;
      emp_q <= en_i && check_empty_i && (&word_i);
      if (en_i && check_fdt_i) begin
        if (word_i == REQA_WORD)      fdt_q <= FDT_W'(REQA_FDT);
        else if (word_i == WUPA_WORD) fdt_q <= FDT_W'(WUPA_FDT);
        else                          unk_q <= 1'b1;
      end
    end
  end

  assign fdt_o     = fdt_q;
  assign unknown_o = unk_q;
  assign empty_o   = emp_q;

  a_r5_fdt_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fdt_q == FDT_W'(REQA_FDT)) || (fdt_q == FDT_W'(WUPA_FDT)));

  a_r6_unknown_keeps_fdt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unk_q |-> $stable(fdt_q));

endmodule

// File: rtl/picc_cmd_rx.sv
module picc_cmd_rx
  import picc_rx_pkg::*;
#(
  parameter int SHORT_WORDS = 16,
  parameter int CONT_WORDS  = 511,
  parameter int FDT_W       = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              sample_i,
  input  logic              release_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              slot_o,
  output logic              buf_full_o,
  output logic              overrun_o,
  output logic [FDT_W-1:0]  fdt_o,
  output logic              unknown_o,
  output logic              empty_o
);

  localparam int MAX_WORDS = (CONT_WORDS > SHORT_WORDS) ? CONT_WORDS : SHORT_WORDS;
  localparam int CNT_W     = $clog2(MAX_WORDS + 1);

  rx_state_e         state_q;
  logic [2:0]        mode_q;
  logic [CNT_W-1:0]  wcnt_q;
  logic [CNT_W-1:0]  cap_last;

  logic              mode_chg;
  logic              hunt, pack_en, sof_hit;
  logic              word_done, cap_end;
  logic [WORD_W-1:0] pack_word;
  logic              store, slot;

  logic [WORD_W-1:0] word_q;
  logic              valid_q, slot_q, full_q;

  assign mode_chg = (mode_i != mode_q);
  assign hunt     = (state_q == ST_HUNT) && !mode_chg;
  assign pack_en  = (state_q == ST_RECV) && !mode_chg;
  assign cap_last = (mode_q == MODE_CONT) ? CNT_W'(CONT_WORDS - 1) : CNT_W'(SHORT_WORDS - 1);
  assign cap_end  = word_done && (wcnt_q == cap_last);

  picc_sof_sync u_sof (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (mode_chg || cap_end),
    .hunt_i   (hunt),
    .sample_i (sample_i),
    .hit_o    (sof_hit)
  );

  picc_word_pack #(.W(WORD_W)) u_pack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (mode_chg),
    .en_i     (pack_en),
    .sample_i (sample_i),
    .done_o   (word_done),
    .word_o   (pack_word)
  );

  picc_pingpong u_pp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (word_done),
    .last_i    (cap_end),
    .release_i (release_i),
    .store_o   (store),
    .slot_o    (slot),
    .overrun_o (overrun_o)
  );

  picc_frame_match #(.FDT_W(FDT_W)) u_match (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (word_done),
    .check_fdt_i   ((mode_q == MODE_SHORT) && (wcnt_q == '0)),
    .check_empty_i (mode_q == MODE_CONT),
    .word_i        (pack_word),
    .fdt_o         (fdt_o),
    .unknown_o     (unknown_o),
    .empty_o       (empty_o)
  );

  function automatic rx_state_e start_state(input logic [2:0] m);
    case (m)
      MODE_SHORT, MODE_STD:    return ST_HUNT;
      MODE_CONT, MODE_ONESHOT: return ST_RECV;
      default:                 return ST_IDLE;
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_NONE;
      wcnt_q  <= '0;
    end else if (mode_chg) begin
      state_q <= start_state(mode_i);
      mode_q  <= mode_i;
      wcnt_q  <= '0;
    end else begin
      case (state_q)
        ST_HUNT: if (sof_hit) state_q <= ST_RECV;
        ST_RECV: if (word_done) begin
          if (cap_end) begin
            wcnt_q <= '0;
            if (mode_q == MODE_ONESHOT)   state_q <= ST_DONE;
            else if (mode_q != MODE_CONT) state_q <= ST_HUNT;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      valid_q <= 1'b0;
      slot_q  <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      valid_q <= store;
      full_q  <= store && cap_end;
      if (store) begin
        word_q <= pack_word;
        slot_q <= slot;
      end
    end
  end

  assign word_o       = word_q;
  assign word_valid_o = valid_q;
  assign slot_o       = slot_q;
  assign buf_full_o   = full_q;

  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |=> !word_valid_o);

  a_r8_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |=> !word_valid_o);

  a_r9_full_with_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_full_o |-> word_valid_o);

  a_r2_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);

endmodule

// File: tb/picc_cmd_rx_tb_top.sv
module picc_cmd_rx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SHORT_W    = 16;
  localparam int CONT_W     = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic        sample = 1'b1;
  logic        release_p = 1'b0;
  logic [31:0] word;
  logic        valid, slot, bfull, ovr, unk, emp;
  logic [15:0] fdt;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  picc_cmd_rx #(.SHORT_WORDS(SHORT_W), .CONT_WORDS(CONT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .sample_i(sample),
    .release_i(release_p), .word_o(word), .word_valid_o(valid),
    .slot_o(slot), .buf_full_o(bfull), .overrun_o(ovr), .fdt_o(fdt),
    .unknown_o(unk), .empty_o(emp)
  );

  logic [31:0] rec_word [128];
  logic        rec_slot [128];
  logic        rec_full [128];
  logic        rec_emp  [128];
  logic        rec_unk  [128];
  logic [15:0] rec_fdt  [128];
  int n_rec   = 0;
  int unk_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (unk) unk_cnt++;
      if (valid && n_rec < 128) begin
        rec_word[n_rec] = word;
        rec_slot[n_rec] = slot;
        rec_full[n_rec] = bfull;
        rec_emp[n_rec]  = emp;
        rec_unk[n_rec]  = unk;
        rec_fdt[n_rec]  = fdt;
        n_rec++;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    sample = b;
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic settle();
    send_bit(1'b1);
    send_bit(1'b1);
  endtask

  task automatic pulse_release();
    @(negedge clk);
    release_p = 1'b1;
    @(negedge clk);
    release_p = 1'b0;
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk);
    mode = m;
  endtask

  // junk that cannot form the pattern, then three zeros and a one
  task automatic short_frame(input logic [31:0] first);
    send_bit(1); send_bit(0); send_bit(1); send_bit(1);
    send_bit(0); send_bit(0); send_bit(0); send_bit(1);
    send_word(first);
    for (int k = 1; k < SHORT_W; k++) send_word(32'h0000_0000);
    settle();
  endtask

  task automatic t_reset();
    chk("R1 word_valid", valid, 0);
    chk("R1 overrun", ovr, 0);
    chk("R1 buf_full", bfull, 0);
    chk("R1 fdt", fdt, 1172);
    chk("R1 unknown", unk, 0);
    chk("R1 empty", emp, 0);
  endtask

  task automatic t_short_wupa();
    int base;
    set_mode(3'd1);
    base = n_rec;
    short_frame(32'h0404_1041);
    chk("R4 word count", n_rec - base, SHORT_W);
    chk("R3 aligned first word", rec_word[base], 32'h0404_1041);
    chk("R5 wupa fdt", rec_fdt[base], 1236);
    chk("R9 first slot", rec_slot[base], 0);
    chk("R9 last slot", rec_slot[base+SHORT_W-1], 0);
    chk("R9 full early", rec_full[base+SHORT_W-2], 0);
    chk("R9 full at end", rec_full[base+SHORT_W-1], 1);
  endtask

  task automatic t_short_reqa();
    int base;
    base = n_rec;
    short_frame(32'h1041_0441);
    chk("R4 second frame count", n_rec - base, SHORT_W);
    chk("R5 reqa fdt", rec_fdt[base], 1172);
    chk("R9 rotated slot", rec_slot[base], 1);
    chk("R9 full slot1", rec_full[base+SHORT_W-1], 1);
  endtask

  task automatic t_overrun();
    int base;
    base = n_rec;
    short_frame(32'h1234_5678);
    chk("R10 dropped words", n_rec - base, 0);
    chk("R10 overrun set", ovr, 1);
    chk("R6 fdt kept on dropped unknown", fdt, 1172);
  endtask

  task automatic t_release_unknown();
    int base, u0;
    pulse_release();
    base = n_rec;
    u0 = unk_cnt;
    short_frame(32'hDEAD_BEEF);
    chk("R9 released slot count", n_rec - base, SHORT_W);
    chk("R9 released slot id", rec_slot[base], 0);
    chk("R3 unknown word aligned", rec_word[base], 32'hDEAD_BEEF);
    chk("R6 unknown pulse", rec_unk[base], 1);
    chk("R6 single pulse", unk_cnt - u0, 1);
    chk("R6 fdt unchanged", rec_fdt[base], 1172);
  endtask

  task automatic t_cont();
    int base;
    logic [31:0] pats [6];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_0F0F; pats[2] = 32'h0000_0001;
    pats[3] = 32'h0000_0002; pats[4] = 32'hFFFF_FFFE; pats[5] = 32'h8000_0001;
    pulse_release();
    pulse_release();
    set_mode(3'd3);
    base = n_rec;
    for (int k = 0; k < CONT_W; k++) send_word(pats[k]);
    for (int k = 0; k < 10; k++) send_bit(k[0]);
    chk("R7 cont count", n_rec - base, CONT_W);
    for (int k = 0; k < CONT_W; k++) chk("R7 cont word", rec_word[base+k], pats[k]);
    chk("R11 empty flagged", rec_emp[base], 1);
    chk("R11 not empty", rec_emp[base+1], 0);
    chk("R11 near all ones", rec_emp[base+4], 0);
    chk("R9 cont slot", rec_slot[base], 1);
    chk("R9 cont full", rec_full[base+CONT_W-1], 1);
  endtask

  task automatic t_oneshot();
    int base;
    set_mode(3'd4);
    base = n_rec;
    for (int k = 0; k < SHORT_W; k++) send_word(32'h1111_1111 + k * 32'h0101_0101);
    for (int k = 0; k < 64; k++) send_bit(k[1]);
    settle();
    chk("R8 one capture only", n_rec - base, SHORT_W);
    chk("R12 restart drops partial", rec_word[base], 32'h1111_1111);
    chk("R8 last word", rec_word[base+SHORT_W-1], 32'h1111_1111 + (SHORT_W-1) * 32'h0101_0101);
    chk("R8 slot", rec_slot[base], 0);
    chk("R8 full at end", rec_full[base+SHORT_W-1], 1);
  endtask

  task automatic t_none();
    int base;
    set_mode(3'd0);
    base = n_rec;
    for (int k = 0; k < 80; k++) send_bit(k[0] ^ k[2]);
    settle();
    chk("R12 none quiet", n_rec - base, 0);
    chk("R10 overrun sticky", ovr, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short_wupa();
    t_short_reqa();
    t_overrun();
    t_release_unknown();
    t_cont();
    t_oneshot();
    t_none();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule